// File: doc/BRIEF.md
# Sleep and cycle statistics counters

This block keeps two statistics counters that run on a slow low-power clock. The cycle counter advances on every slow-clock edge. The sleep counter advances only on the edges where the MAC's sleep indication is high. Both counters are read through a small register window on the host clock. Every value returned is a coherent snapshot, so a 32-bit read is never a mix of two counter states.

The host can zero both counters, or load either one with a value for diagnostics. Each request crosses into the slow domain as a toggle. While it is in flight, a pending flag is visible in the control register, and software polls that flag before each access. Only one request is in flight at a time. A level interrupt follows the top bit of the cycle counter. When the cycle counter reaches all ones, both counters stop.

Register window (byte offsets): 0x0 is control, where bit 0 is clear and bit 1 is pending; 0x4 is the cycle counter; 0x8 is the sleep counter. Any other offset reads 0 and ignores writes.

Top module: `sleep_cycle_stats`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and pending is 0.
- R2: With no request landing and the cycle counter below all ones, the cycle counter increases by exactly 1 on each slow-clock edge.
- R3: The sleep counter increases on slow edge k only when `mac_sleep` was high at slow edge k-2, because the input passes a two-stage synchronizer first. Otherwise it holds.
- R4: Once the cycle counter holds 0xFFFF_FFFF, neither counter changes until a host request lands. The sleep counter never wraps past 0xFFFF_FFFF.
- R5: `irq` equals bit 31 of the cycle counter once the host domain has settled. It falls when a clear or a load brings that bit to 0.
- R6: Writing 1 to control bit 0 zeroes both counters on the third slow edge after the write is accepted. Neither counter counts on that edge.
- R7: Control bit 1 (pending) reads 1 from the host cycle after a write is accepted until that request has taken effect. Control bit 0 reads 1 only while a clear is pending, and reads 0 after it completes.
- R8: A host write to offset 0x4 or 0x8 loads that counter with the written value on the third slow edge after acceptance. The other counter holds on that edge.
- R9: Any write issued while pending is 1 is dropped, and it leaves no trace in the counters.
- R10: A counter read returns the value the counter took at the latest slow edge, once four host cycles have passed since that edge.
- R11: A control write with bit 0 at 0, or a write to an unmapped offset, starts no request and leaves pending at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host register clock |
| rst_n | input | 1 | Asynchronous active-low reset, host domain |
| lp_clk | input | 1 | Slow low-power counting clock |
| lp_rst_n | input | 1 | Asynchronous active-low reset, slow domain |
| mac_sleep | input | 1 | High while the MAC is asleep (asynchronous) |
| reg_addr | input | 4 | Byte offset into the register window |
| reg_wr_en | input | 1 | Write strobe for one host cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt that follows cycle counter bit 31 |

## Verification
The sleep input is driven in three patterns: held low, held high, and alternated with runs of different lengths. Held low separates the two counters. Held high checks that the sleep counter tracks the cycle counter. Alternation shows the two-edge synchronizer delay in the sleep count. Host requests are issued at the boundaries: a clear with further writes behind it while pending, a load just below bit 31, a load just below all ones, and a load of the sleep counter at all ones. These show where a request lands, how saturation holds, how the interrupt follows bit 31, and how late writes are dropped.

// File: rtl/slpstat_pkg.sv
`timescale 1ns/1ps
package slpstat_pkg;

    // Host request carried into the slow domain
    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_CLEAR    = 2'd1,
        OP_LOAD_CYC = 2'd2,
        OP_LOAD_SLP = 2'd3
    } op_kind_e;

    // Word index of each register (byte offset / 4)
    localparam int IDX_CTRL = 0;
    localparam int IDX_CYC  = 1;
    localparam int IDX_SLP  = 2;

    // Control register fields
    localparam int CTRL_CLR_BIT  = 0;
    localparam int CTRL_PEND_BIT = 1;

endpackage

// File: rtl/slpstat_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for independent single-bit signals
module slpstat_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/slpstat_core.sv
`timescale 1ns/1ps
// Slow-domain counters: cycle/sleep counting, saturation, request landing
module slpstat_core
    import slpstat_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             lp_clk,
    input  logic             lp_rst_n,
    input  logic             mac_sleep,
    input  logic             req_tog,
    input  op_kind_e         op_kind,
    input  logic [CNT_W-1:0] op_data,
    output logic             ack_tog,
    output logic             pub_tog,
    output logic [CNT_W-1:0] cyc_cnt,
    output logic [CNT_W-1:0] slp_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             seen;
        logic             pub;
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] slp;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [1:0]  sync_q;
    logic        sleep_s, req_s, fire, cyc_sat;

    slpstat_sync #(.W(2), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk   (lp_clk),
        .rst_n (lp_rst_n),
        .d     ({mac_sleep, req_tog}),
        .q     (sync_q)
    );

    assign sleep_s = sync_q[1];
    assign req_s   = sync_q[0];
    assign fire    = req_s ^ st_q.seen;
    assign cyc_sat = (st_q.cyc == CNT_MAX);

    always_comb begin
        st_d      = st_q;
        st_d.seen = req_s;
        st_d.pub  = ~st_q.pub;
        if (fire) begin
            unique case (op_kind)
                OP_CLEAR: begin
                    st_d.cyc = '0;
                    st_d.slp = '0;
                end
                OP_LOAD_CYC: st_d.cyc = op_data;
                OP_LOAD_SLP: st_d.slp = op_data;
                default: ;
            endcase
        end else if (!cyc_sat) begin
            st_d.cyc = st_q.cyc + 1'b1;
            if (sleep_s && (st_q.slp != CNT_MAX)) begin
                st_d.slp = st_q.slp + 1'b1;
            end
        end
    end

    always_ff @(posedge lp_clk or negedge lp_rst_n) begin
        if (!lp_rst_n) st_q <= '0;
        else           st_q <= st_d;
    end

    assign ack_tog = st_q.seen;
    assign pub_tog = st_q.pub;
    assign cyc_cnt = st_q.cyc;
    assign slp_cnt = st_q.slp;

    p_cycle_step_r2: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        (!fire && !cyc_sat) |=> (st_q.cyc == $past(st_q.cyc) + 1'b1));

    p_sleep_gate_r3: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        (!fire && !sleep_s) |=> $stable(st_q.slp));

    p_saturate_r4: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        (!fire && cyc_sat) |=> ($stable(st_q.cyc) && $stable(st_q.slp)));

    p_clear_r6: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        (fire && op_kind == OP_CLEAR) |=> (st_q.cyc == '0 && st_q.slp == '0));

    p_load_cyc_r8: assert property (@(posedge lp_clk) disable iff (!lp_rst_n)
        (fire && op_kind == OP_LOAD_CYC) |=> (st_q.cyc == $past(op_data) && $stable(st_q.slp)));
endmodule

// File: rtl/slpstat_host.sv
`timescale 1ns/1ps
// Host-domain register window, request issue and snapshot capture
module slpstat_host
    import slpstat_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              req_tog,
    output op_kind_e          op_kind,
    output logic [CNT_W-1:0]  op_data,
    input  logic              ack_tog,
    input  logic              pub_tog,
    input  logic              cyc_msb,
    input  logic [CNT_W-1:0]  cyc_cnt,
    input  logic [CNT_W-1:0]  slp_cnt
);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic             req_tog;
        op_kind_e         kind;
        logic [CNT_W-1:0] data;
        logic             ack_seen;
        logic             pub_seen;
        logic [CNT_W-1:0] cyc_snap;
        logic [CNT_W-1:0] slp_snap;
    } host_state_t;

    host_state_t       st_d, st_q;
    logic [2:0]        sync_q;
    logic              ack_s, pub_s, irq_s, pend, accept;
    logic [WORD_W-1:0] word;
    op_kind_e          wr_op;

    slpstat_sync #(.W(3), .STAGES(SYNC_STAGES)) u_back_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cyc_msb, ack_tog, pub_tog}),
        .q     (sync_q)
    );

    assign irq_s = sync_q[2];
    assign ack_s = sync_q[1];
    assign pub_s = sync_q[0];
    assign word  = reg_addr[ADDR_W-1:2];
    assign pend  = st_q.req_tog ^ st_q.ack_seen;

    // Decode the write into a request kind
    always_comb begin
        wr_op = OP_NONE;
        if (word == WORD_W'(IDX_CTRL)) begin
            if (reg_wdata[CTRL_CLR_BIT]) wr_op = OP_CLEAR;
        end else if (word == WORD_W'(IDX_CYC)) begin
            wr_op = OP_LOAD_CYC;
        end else if (word == WORD_W'(IDX_SLP)) begin
            wr_op = OP_LOAD_SLP;
        end
    end

    assign accept = reg_wr_en && !pend && (wr_op != OP_NONE);

    always_comb begin
        st_d          = st_q;
        st_d.ack_seen = ack_s;
        if (accept) begin
            st_d.req_tog = ~st_q.req_tog;
            st_d.kind    = wr_op;
            st_d.data    = reg_wdata;
        end
        if (pub_s != st_q.pub_seen) begin
            st_d.pub_seen = pub_s;
            st_d.cyc_snap = cyc_cnt;
            st_d.slp_snap = slp_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (word == WORD_W'(IDX_CTRL)) begin
            reg_rdata[CTRL_PEND_BIT] = pend;
            reg_rdata[CTRL_CLR_BIT]  = pend && (st_q.kind == OP_CLEAR);
        end else if (word == WORD_W'(IDX_CYC)) begin
            reg_rdata = st_q.cyc_snap;
        end else if (word == WORD_W'(IDX_SLP)) begin
            reg_rdata = st_q.slp_snap;
        end
    end

    assign irq     = irq_s;
    assign req_tog = st_q.req_tog;
    assign op_kind = st_q.kind;
    assign op_data = st_q.data;

    p_accept_pends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pend);

    p_hold_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> ($stable(op_data) && $stable(op_kind) && $stable(req_tog)));

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !accept) |=> !pend);
endmodule

// File: rtl/sleep_cycle_stats.sv
`timescale 1ns/1ps
// Top: slow-clock sleep/cycle statistics counters with host register window
module sleep_cycle_stats
    import slpstat_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lp_clk,
    input  logic              lp_rst_n,
    input  logic              mac_sleep,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    logic             req_tog, ack_tog, pub_tog;
    op_kind_e         op_kind;
    logic [CNT_W-1:0] op_data, cyc_cnt, slp_cnt;

    slpstat_host #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq),
        .req_tog   (req_tog),
        .op_kind   (op_kind),
        .op_data   (op_data),
        .ack_tog   (ack_tog),
        .pub_tog   (pub_tog),
        .cyc_msb   (cyc_cnt[CNT_W-1]),
        .cyc_cnt   (cyc_cnt),
        .slp_cnt   (slp_cnt)
    );

    slpstat_core #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .lp_clk    (lp_clk),
        .lp_rst_n  (lp_rst_n),
        .mac_sleep (mac_sleep),
        .req_tog   (req_tog),
        .op_kind   (op_kind),
        .op_data   (op_data),
        .ack_tog   (ack_tog),
        .pub_tog   (pub_tog),
        .cyc_cnt   (cyc_cnt),
        .slp_cnt   (slp_cnt)
    );
endmodule

// File: tb/sleep_cycle_stats_tb.sv
`timescale 1ns/1ps
module sleep_cycle_stats_tb_top;
    logic        clk = 1'b0, rst_n = 1'b0, lp_clk = 1'b0, lp_rst_n = 1'b0;
    logic        mac_sleep = 1'b0, reg_wr_en = 1'b0, irq;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;

    always #4 clk = ~clk;  // 125 MHz host clock

    sleep_cycle_stats dut_i (
        .clk(clk), .rst_n(rst_n), .lp_clk(lp_clk), .lp_rst_n(lp_rst_n),
        .mac_sleep(mac_sleep), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int checks = 0, errors = 0;

    // Reference model state
    logic [31:0] m_cyc = '0, m_slp = '0, m_data = '0;
    bit          m_pend = 0, m_clr = 0;
    int          m_kind = 0, m_countdown = 0;
    bit          sleep_hist[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic compare_all(input string ctx);
        logic [31:0] v;
        rd(4'h0, v); chk({"R7 control ", ctx}, v, {30'b0, m_pend, m_pend & m_clr});
        rd(4'h4, v); chk({"R2 R10 cycle ", ctx}, v, m_cyc);
        rd(4'h8, v); chk({"R3 R10 sleep ", ctx}, v, m_slp);
        chk({"R5 irq ", ctx}, {31'b0, irq}, {31'b0, m_cyc[31]});
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        int kind;
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        kind = (a == 4'h0) ? (d[0] ? 1 : 0) : (a == 4'h4) ? 2 : (a == 4'h8) ? 3 : 0;
        if (kind != 0 && !m_pend) begin   // R9: dropped while pending
            m_pend = 1; m_clr = (kind == 1); m_kind = kind; m_data = d; m_countdown = 3;
        end
        reg_addr = 4'h0;
        #1 chk("R7 R9 R11 control after write", reg_rdata, {30'b0, m_pend, m_pend & m_clr});
    endtask

    // One slow-clock cycle, model update, then settle and compare
    task automatic tick();
        bit delayed;
        sleep_hist.push_back(mac_sleep);
        delayed = (sleep_hist.size() >= 3) ? sleep_hist[sleep_hist.size()-3] : 1'b0;
        @(negedge clk);
        lp_clk = 1'b1;
        if (m_countdown == 1) begin        // R6 R8: request lands, no counting
            case (m_kind)
                1: begin m_cyc = '0; m_slp = '0; end
                2: m_cyc = m_data;
                3: m_slp = m_data;
                default: ;
            endcase
            m_pend = 0; m_clr = 0;
        end else if (m_cyc != 32'hFFFF_FFFF) begin  // R4 saturation
            m_cyc = m_cyc + 1;
            if (delayed && m_slp != 32'hFFFF_FFFF) m_slp = m_slp + 1;
        end
        if (m_countdown > 0) m_countdown--;
        repeat (4) @(negedge clk);
        lp_clk = 1'b0;
        repeat (4) @(negedge clk);
        compare_all("tick");
    endtask

    initial begin
        #1_000_000;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1; lp_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(4'h0, v); chk("R1 control", v, 32'h0);
        rd(4'h4, v); chk("R1 cycle", v, 32'h0);
        rd(4'h8, v); chk("R1 sleep", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // Awake: only the cycle counter moves
        repeat (5) tick();
        // Sleep high, then alternating runs
        mac_sleep = 1'b1; repeat (4) tick();
        mac_sleep = 1'b0; tick();
        mac_sleep = 1'b1; tick(); tick();
        mac_sleep = 1'b0; repeat (3) tick();

        // R6 clear, with R9 writes dropped while pending
        wr(4'h0, 32'h1);
        wr(4'h4, 32'h0000_1234);
        wr(4'h0, 32'h1);
        repeat (4) tick();

        // R11 control write with bit 0 low, unmapped write
        wr(4'h0, 32'h2);
        wr(4'hC, 32'h5);
        tick();

        // R8 load cycle below bit 31, R5 irq rises
        wr(4'h4, 32'h7FFF_FFFE);
        repeat (5) tick();

        // R8 load sleep, then R4 saturation of both counters
        mac_sleep = 1'b1;
        wr(4'h8, 32'h0000_0020);
        repeat (4) tick();
        wr(4'h4, 32'hFFFF_FFFC);
        repeat (7) tick();

        // R6 clear drops irq (R5)
        wr(4'h0, 32'h1);
        repeat (3) tick();

        // R4 sleep counter at all ones does not wrap
        wr(4'h8, 32'hFFFF_FFFE);
        repeat (3) tick();
        repeat (4) tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule